// File: doc/BRIEF.md
# Data Watchpoint Match Unit

This block holds a bank of data watchpoints. Each watchpoint has a 32-bit control word and an address value. Both are written and read back through a small register port that selects a watchpoint by index. On every clock where a memory access is presented (address, size code, load/store flag, valid), every watchpoint checks the access. A watchpoint applies its enable, its access-type filter, its power-of-two address mask and its byte-lane select. One clock later the block reports a hit flag and the index of the lowest-numbered watchpoint that matched.

Reserved encodings are handled as disabled watchpoints. These are a mask size of 1 or 2, a load/store selector of 0, and a lane select that is zero or has gaps. Software still reads back exactly what it wrote into the implemented fields. The security-state field, the higher-mode bit, the privilege field, the link type bit and the linked breakpoint number are stored but have no effect on matching.

The result is held by a two-state report machine. RS_IDLE means that no hit is being reported. RS_HIT means that the access sampled on the previous edge matched. The machine has four transitions: IDLE→HIT when an access matches, HIT→HIT when a further access matches, HIT→IDLE when the next cycle has no match or no access, and IDLE→IDLE otherwise. The bank index of the match is captured on the same edge.

Top module: `data_watch_unit`

## Requirements
- R1: A write with `reg_sel_val`=0 stores a control word and one with `reg_sel_val`=1 stores an address value, into the watchpoint chosen by `reg_idx`. `reg_rdata` shows the selected word combinationally. In the control word, bits [31:29] and [23:21] read as zero. In the value, bits [1:0] read as zero. Every other bit reads back as written, including reserved mask codes.
- R2: A synchronous reset (`rst`=1) clears every control word and value to zero. After reset, `hit` stays 0 until a watchpoint is programmed.
- R3: A watchpoint whose enable bit (control bit 0) is 0 never matches.
- R4: With mask code 0 (control bits [28:24]), a watchpoint matches only when the access address bits [31:3] equal the value bits [31:3] and at least one touched byte falls on a selected lane. The access touches 2^`acc_size` bytes starting at offset `acc_addr`[2:0] of its double-word, and bytes beyond offset 7 are dropped. Lane select bit k (control bits [12:5]) watches byte (value & ~3) + k.
- R5: When value bit 2 is 1, only lane bits [3:0] are used and they watch double-word offsets 4 to 7. Lane bits [7:4] are ignored.
- R6: A mask code m from 3 to 31 makes the watchpoint match any access whose address bits [31:m] equal the value's bits [31:m], whatever the lane select holds.
- R7: Mask codes 1 and 2 make the watchpoint never match.
- R8: Load/store selector (control bits [4:3]): 01 matches loads only (`acc_store`=0), 10 matches stores only, 11 matches both, and 00 never matches.
- R9: A lane select of zero, or one whose set bits are not contiguous, makes the watchpoint never match.
- R10: `hit` and `hit_idx` reflect the access presented on the previous clock edge. `hit_idx` is the lowest matching index. When nothing matched, or no access was valid, `hit` is 0 and `hit_idx` is 0.
- R11: Control bits 20, [19:16], [15:14], 13 and [2:1] are stored and read back but do not change any match result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_we | input | 1 | Register write strobe |
| reg_sel_val | input | 1 | 0 selects the control word, 1 selects the address value |
| reg_idx | input | IDX_W (4) | Watchpoint index for register access |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for the selected word |
| acc_valid | input | 1 | Access present this cycle |
| acc_addr | input | ADDR_W (32) | Access byte address |
| acc_size | input | 2 | Access size code: 0=1, 1=2, 2=4, 3=8 bytes |
| acc_store | input | 1 | 1 for a store, 0 for a load |
| hit | output | 1 | Registered match flag |
| hit_idx | output | IDX_W (4) | Registered lowest matching index |

## Verification
Directed accesses of each size walk across the edges of the watched lanes in both halves of a double-word. They show whether the lane mapping, the bit-2 remap and the dropping of bytes beyond offset 7 are right. Separate patterns pair one address with loads and with stores under each selector code, and with each reserved mask and lane code. These tell filtering faults apart from address-compare faults. Two overlapping watchpoints with different indices check the priority order. Long random mixes of register writes and accesses over a small address window, with masks from 0 to 14, are compared every clock against a behavioural per-byte model. That model also covers a write and an access landing on the same edge.

// File: rtl/dwu_pkg.sv
package dwu_pkg;

    typedef enum logic {
        RS_IDLE,
        RS_HIT
    } rpt_state_t;

    // Bits that hold storage in a control word; the rest read as zero.
    localparam logic [31:0] CTRL_KEEP = 32'h1F1F_FFFF;

    // A lane select is legal when non-zero and its set bits form one run.
    function automatic logic lanes_legal(input logic [7:0] b);
        logic [7:0] low;
        logic [8:0] sum;
        low = b & (~b + 8'd1);
        sum = {1'b0, b} + {1'b0, low};
        return (b != 8'd0) && ((sum[7:0] & b) == 8'd0);
    endfunction

    // Byte lanes touched inside the double-word by an access.
    function automatic logic [7:0] touched_lanes(input logic [2:0] off,
                                                 input logic [1:0] sz);
        logic [7:0]  base;
        logic [15:0] wide;
        unique case (sz)
            2'd0: base = 8'h01;
            2'd1: base = 8'h03;
            2'd2: base = 8'h0F;
            default: base = 8'hFF;
        endcase
        wide = {8'd0, base} << off;
        return wide[7:0];
    endfunction

endpackage

// File: rtl/dwu_regbank.sv
module dwu_regbank #(
    parameter int NUM_WP = 16,
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 4
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            we,
    input  logic                            sel_val,
    input  logic [IDX_W-1:0]                idx,
    input  logic [31:0]                     wdata,
    output logic [31:0]                     rdata,
    output logic [NUM_WP-1:0]               en_o,
    output logic [NUM_WP-1:0][4:0]          mask_o,
    output logic [NUM_WP-1:0][7:0]          lanes_o,
    output logic [NUM_WP-1:0][1:0]          ldst_o,
    output logic [NUM_WP-1:0][ADDR_W-1:0]   val_o
);
    import dwu_pkg::*;

    logic [NUM_WP-1:0][31:0]       ctrl_q;
    logic [NUM_WP-1:0][ADDR_W-1:0] val_q;

    for (genvar g = 0; g < NUM_WP; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                ctrl_q[g] <= '0;
                val_q[g]  <= '0;
            end else if (we && (idx == IDX_W'(g))) begin
                if (sel_val)
                    val_q[g] <= ADDR_W'(wdata) & ~ADDR_W'(3);
                else
                    ctrl_q[g] <= wdata & CTRL_KEEP;
            end
        end
        assign en_o[g]    = ctrl_q[g][0];
        assign mask_o[g]  = ctrl_q[g][28:24];
        assign lanes_o[g] = ctrl_q[g][12:5];
        assign ldst_o[g]  = ctrl_q[g][4:3];
        assign val_o[g]   = val_q[g];
    end

    always_comb begin
        rdata = '0;
        if (int'(idx) < NUM_WP) begin
            if (sel_val)
                rdata = 32'(val_q[idx]);
            else
                rdata = ctrl_q[idx];
        end
    end

endmodule

// File: rtl/dwu_wp_match.sv
module dwu_wp_match #(
    parameter int ADDR_W = 32
) (
    input  logic              en,
    input  logic [4:0]        mask,
    input  logic [7:0]        lanes,
    input  logic [1:0]        ldst,
    input  logic [ADDR_W-1:0] val,
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        size,
    input  logic              store,
    output logic              match
);
    import dwu_pkg::*;

    logic              armed;
    logic              kind_ok;
    logic              addr_ok;
    logic              lane_ok;
    logic [7:0]        watch;
    logic [ADDR_W-1:0] keep;

    always_comb begin
        armed   = en && (ldst != 2'b00) && (mask != 5'd1) && (mask != 5'd2)
                  && lanes_legal(lanes);
        kind_ok = store ? ldst[1] : ldst[0];
        watch   = val[2] ? {lanes[3:0], 4'b0000} : lanes;
        keep    = {ADDR_W{1'b1}} << mask;
        if (mask == 5'd0) begin
            addr_ok = (addr[ADDR_W-1:3] == val[ADDR_W-1:3]);
            lane_ok = |(touched_lanes(addr[2:0], size) & watch);
        end else begin
            addr_ok = (((addr ^ val) & keep) == '0);
            lane_ok = 1'b1;
        end
        match = armed && kind_ok && addr_ok && lane_ok;
    end

endmodule

// File: rtl/dwu_first_hit.sv
module dwu_first_hit #(
    parameter int N     = 16,
    parameter int IDX_W = 4
) (
    input  logic [N-1:0]     req,
    output logic             any,
    output logic [IDX_W-1:0] first
);
    always_comb begin
        any   = |req;
        first = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) first = IDX_W'(i);
        end
    end
endmodule

// File: rtl/data_watch_unit.sv
module data_watch_unit #(
    parameter int NUM_WP = 16,
    parameter int ADDR_W = 32,
    localparam int IDX_W = $clog2(NUM_WP)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic              reg_sel_val,
    input  logic [IDX_W-1:0]  reg_idx,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              acc_valid,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [1:0]        acc_size,
    input  logic              acc_store,
    output logic              hit,
    output logic [IDX_W-1:0]  hit_idx
);
    import dwu_pkg::*;

    logic [NUM_WP-1:0]             en_w;
    logic [NUM_WP-1:0][4:0]        mask_w;
    logic [NUM_WP-1:0][7:0]        lanes_w;
    logic [NUM_WP-1:0][1:0]        ldst_w;
    logic [NUM_WP-1:0][ADDR_W-1:0] val_w;
    logic [NUM_WP-1:0]             match_w;
    logic                          any_w;
    logic [IDX_W-1:0]              first_w;

    rpt_state_t       state_q, state_d;
    logic [IDX_W-1:0] idx_q;

    dwu_regbank #(.NUM_WP(NUM_WP), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_bank (
        .clk(clk), .rst(rst), .we(reg_we), .sel_val(reg_sel_val),
        .idx(reg_idx), .wdata(reg_wdata), .rdata(reg_rdata),
        .en_o(en_w), .mask_o(mask_w), .lanes_o(lanes_w),
        .ldst_o(ldst_w), .val_o(val_w)
    );

    for (genvar g = 0; g < NUM_WP; g++) begin : g_cmp
        dwu_wp_match #(.ADDR_W(ADDR_W)) u_cmp (
            .en(en_w[g]), .mask(mask_w[g]), .lanes(lanes_w[g]),
            .ldst(ldst_w[g]), .val(val_w[g]), .addr(acc_addr),
            .size(acc_size), .store(acc_store), .match(match_w[g])
        );
    end

    dwu_first_hit #(.N(NUM_WP), .IDX_W(IDX_W)) u_pick (
        .req(match_w), .any(any_w), .first(first_w)
    );

    // Next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RS_IDLE: state_d = (acc_valid && any_w) ? RS_HIT : RS_IDLE;
            RS_HIT:  state_d = (acc_valid && any_w) ? RS_HIT : RS_IDLE;
            default: state_d = RS_IDLE;
        endcase
    end

    // State register and captured index
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= RS_IDLE;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= (acc_valid && any_w) ? first_w : '0;
        end
    end

    // Outputs
    always_comb begin
        unique case (state_q)
            RS_HIT: begin
                hit     = 1'b1;
                hit_idx = idx_q;
            end
            default: begin
                hit     = 1'b0;
                hit_idx = '0;
            end
        endcase
    end

endmodule

// File: rtl/dwu_chk.sv
module dwu_chk #(
    parameter int IDX_W = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             acc_valid,
    input logic             reg_sel_val,
    input logic [31:0]      reg_rdata,
    input logic             hit,
    input logic [IDX_W-1:0] hit_idx
);
    // R10
    no_idle_hit_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(acc_valid) |-> !hit);

    // R10
    idx_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !hit |-> (hit_idx == '0));

    // R2
    reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !hit);

    // R1
    ctrl_zero_bits_chk: assert property (@(posedge clk) disable iff (rst)
        !reg_sel_val |-> (reg_rdata[31:29] == 3'd0 && reg_rdata[23:21] == 3'd0));

    // R1
    val_low_bits_chk: assert property (@(posedge clk) disable iff (rst)
        reg_sel_val |-> (reg_rdata[1:0] == 2'd0));
endmodule

bind data_watch_unit dwu_chk #(.IDX_W(IDX_W)) u_chk (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .reg_sel_val(reg_sel_val),
    .reg_rdata(reg_rdata), .hit(hit), .hit_idx(hit_idx)
);

// File: tb/sim_data_watch_unit.sv
`timescale 1ns/1ps
module sim_data_watch_unit;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic        reg_sel_val = 1'b0;
    logic [3:0]  reg_idx = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        acc_valid = 1'b0;
    logic [31:0] acc_addr = '0;
    logic [1:0]  acc_size = '0;
    logic        acc_store = 1'b0;
    logic        hit;
    logic [3:0]  hit_idx;

    int    n_run  = 0;
    int    n_fail = 0;
    string cur_req = "R2";
    bit    cmp_on = 1'b0;

    logic [31:0] m_ctrl [16];
    logic [31:0] m_val  [16];
    bit          exp_hit = 1'b0;
    logic [3:0]  exp_idx = '0;

    always #4 clk = ~clk;

    data_watch_unit u0 (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_sel_val(reg_sel_val),
        .reg_idx(reg_idx), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .acc_valid(acc_valid), .acc_addr(acc_addr), .acc_size(acc_size),
        .acc_store(acc_store), .hit(hit), .hit_idx(hit_idx)
    );

    function automatic bit ref_match(logic [31:0] c, logic [31:0] v,
                                     logic [31:0] a, int sz, bit st);
        int mk, first, last, nb;
        logic [7:0] ln;
        logic [1:0] ls;
        logic [32:0] b, vb;
        mk = int'(c[28:24]); ln = c[12:5]; ls = c[4:3];
        if (!c[0] || mk == 1 || mk == 2 || ls == 2'b00) return 0;
        if (st && !ls[1]) return 0;
        if (!st && !ls[0]) return 0;
        first = -1; last = -1;
        for (int k = 0; k < 8; k++) if (ln[k]) begin
            if (first < 0) first = k;
            last = k;
        end
        if (first < 0) return 0;
        for (int k = 0; k < 8; k++)
            if (k >= first && k <= last && !ln[k]) return 0;
        nb = 1 << sz;
        for (int j = 0; j < nb; j++) begin
            int o;
            o = int'(a[2:0]) + j;
            if (o > 7) continue;
            b = {1'b0, a[31:3], 3'b000} + 33'(o);
            if (mk != 0) begin
                if ((b >> mk) == ({1'b0, v} >> mk)) return 1;
            end else begin
                for (int k = 0; k < 8; k++) begin
                    vb = {1'b0, v & 32'hFFFF_FFFC} + 33'(k);
                    if (ln[k] && (k < 4 || !v[2]) && b == vb) return 1;
                end
            end
        end
        return 0;
    endfunction

    // Behavioural reference, advanced on every edge
    always @(posedge clk) begin
        if (rst) begin
            exp_hit = 0; exp_idx = 0;
            for (int i = 0; i < 16; i++) begin m_ctrl[i] = 0; m_val[i] = 0; end
        end else begin
            exp_hit = 0; exp_idx = 0;
            if (acc_valid)
                for (int i = 15; i >= 0; i--)
                    if (ref_match(m_ctrl[i], m_val[i], acc_addr, int'(acc_size), acc_store)) begin
                        exp_hit = 1; exp_idx = 4'(i);
                    end
            if (reg_we) begin
                if (reg_sel_val) m_val[reg_idx]  = reg_wdata & 32'hFFFF_FFFC;
                else             m_ctrl[reg_idx] = reg_wdata & 32'h1F1F_FFFF;
            end
        end
    end

    always @(negedge clk) begin
        if (cmp_on) begin
            n_run++;
            if (hit !== exp_hit || hit_idx !== exp_idx) begin
                n_fail++;
                $display("FAIL %s per-cycle: hit=%0b idx=%0d expected hit=%0b idx=%0d",
                         cur_req, hit, hit_idx, exp_hit, exp_idx);
            end
        end
    end

    function automatic logic [31:0] mkc(int mask, int lanes, int ldst, int en);
        return (32'(mask) << 24) | (32'(lanes) << 5) | (32'(ldst) << 3) | 32'(en);
    endfunction

    task automatic wr(int idx, bit sv, logic [31:0] d);
        @(negedge clk);
        reg_we = 1; reg_sel_val = sv; reg_idx = 4'(idx); reg_wdata = d;
        @(negedge clk);
        reg_we = 0;
    endtask

    task automatic rd_chk(int idx, bit sv, logic [31:0] e, string req);
        @(negedge clk);
        reg_idx = 4'(idx); reg_sel_val = sv;
        #1;
        n_run++;
        if (reg_rdata !== e) begin
            n_fail++;
            $display("FAIL %s readback idx=%0d: got %h expected %h", req, idx, reg_rdata, e);
        end
    endtask

    task automatic acc(logic [31:0] a, int sz, bit st, bit eh, int ei, string req);
        cur_req = req;
        @(negedge clk);
        acc_valid = 1; acc_addr = a; acc_size = 2'(sz); acc_store = st;
        @(negedge clk);
        acc_valid = 0;
        n_run++;
        if (hit !== eh || hit_idx !== 4'(ei)) begin
            n_fail++;
            $display("FAIL %s access %h: hit=%0b idx=%0d expected hit=%0b idx=%0d",
                     req, a, hit, hit_idx, eh, ei);
        end
    endtask

    task automatic clear_all();
        for (int i = 0; i < 16; i++) wr(i, 0, 32'h0);
    endtask

    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        cmp_on = 1;
        // R2: reset state
        rd_chk(0, 0, 32'h0, "R2");
        rd_chk(15, 1, 32'h0, "R2");
        acc(32'h0, 3, 0, 0, 0, "R2");
        acc(32'h0, 3, 1, 0, 0, "R2");

        // R1: readback masking
        wr(5, 0, 32'hFFFF_FFFF);
        rd_chk(5, 0, 32'h1F1F_FFFF, "R1");
        wr(5, 1, 32'hFFFF_FFFF);
        rd_chk(5, 1, 32'hFFFF_FFFC, "R1");
        clear_all();

        // R4: unmasked lanes 2..3 at 0x1000
        wr(0, 1, 32'h1000);
        wr(0, 0, mkc(0, 8'h0C, 3, 1));
        acc(32'h1002, 0, 0, 1, 0, "R4");
        acc(32'h1001, 0, 0, 0, 0, "R4");
        acc(32'h1000, 2, 1, 1, 0, "R4");
        acc(32'h1004, 2, 0, 0, 0, "R4");
        acc(32'h1008, 3, 0, 0, 0, "R4");
        acc(32'h1003, 1, 0, 1, 0, "R4");
        acc(32'h1000, 3, 0, 1, 0, "R4");
        // R3: enable cleared
        wr(0, 0, mkc(0, 8'h0C, 3, 0));
        acc(32'h1002, 0, 0, 0, 0, "R3");

        // R5: value bit 2 set
        wr(1, 1, 32'h2004);
        wr(1, 0, mkc(0, 8'h18, 3, 1));
        acc(32'h2007, 0, 0, 1, 1, "R5");
        acc(32'h2008, 0, 0, 0, 0, "R5");
        acc(32'h2003, 0, 0, 0, 0, "R5");
        wr(1, 0, mkc(0, 8'h01, 3, 1));
        acc(32'h2004, 0, 0, 1, 1, "R5");
        acc(32'h2000, 0, 0, 0, 0, "R5");
        wr(1, 0, 0);

        // R6: masked compare
        wr(2, 1, 32'h3_0000);
        wr(2, 0, mkc(12, 8'h01, 3, 1));
        acc(32'h3_0FF8, 0, 1, 1, 2, "R6");
        acc(32'h3_1000, 0, 1, 0, 0, "R6");
        wr(2, 1, 32'h8000_0000);
        wr(2, 0, mkc(31, 8'h01, 3, 1));
        acc(32'hFFFF_FFF0, 2, 0, 1, 2, "R6");
        acc(32'h7FFF_FFF0, 2, 0, 0, 0, "R6");

        // R7: reserved mask codes
        wr(2, 1, 32'h4000);
        wr(2, 0, mkc(1, 8'h01, 3, 1));
        acc(32'h4000, 0, 0, 0, 0, "R7");
        rd_chk(2, 0, mkc(1, 8'h01, 3, 1), "R7");
        wr(2, 0, mkc(2, 8'h01, 3, 1));
        acc(32'h4000, 0, 0, 0, 0, "R7");
        wr(2, 0, mkc(3, 8'h01, 3, 1));
        acc(32'h4006, 0, 0, 1, 2, "R6");
        wr(2, 0, 0);

        // R8: load/store selector
        wr(4, 1, 32'h5000);
        wr(4, 0, mkc(0, 8'h01, 1, 1));
        acc(32'h5000, 0, 0, 1, 4, "R8");
        acc(32'h5000, 0, 1, 0, 0, "R8");
        wr(4, 0, mkc(0, 8'h01, 2, 1));
        acc(32'h5000, 0, 0, 0, 0, "R8");
        acc(32'h5000, 0, 1, 1, 4, "R8");
        wr(4, 0, mkc(0, 8'h01, 0, 1));
        acc(32'h5000, 0, 1, 0, 0, "R8");
        acc(32'h5000, 0, 0, 0, 0, "R8");

        // R9: illegal lane selects
        wr(4, 0, mkc(0, 8'h05, 3, 1));
        acc(32'h5000, 3, 0, 0, 0, "R9");
        wr(4, 0, mkc(0, 8'h00, 3, 1));
        acc(32'h5000, 3, 0, 0, 0, "R9");
        wr(4, 0, 0);

        // R10: priority and idle cycles
        wr(3, 1, 32'h6000); wr(7, 1, 32'h6000);
        wr(3, 0, mkc(0, 8'hFF, 3, 1)); wr(7, 0, mkc(0, 8'hFF, 3, 1));
        acc(32'h6004, 0, 0, 1, 3, "R10");
        wr(3, 0, 0);
        acc(32'h6004, 0, 0, 1, 7, "R10");
        cur_req = "R10";
        repeat (2) @(negedge clk);
        n_run++;
        if (hit !== 1'b0) begin
            n_fail++;
            $display("FAIL R10 idle: hit=%0b expected 0", hit);
        end

        // R11: unevaluated fields set
        wr(7, 0, mkc(0, 8'hFF, 3, 1) | 32'h001F_E006);
        acc(32'h6001, 0, 1, 1, 7, "R11");
        rd_chk(7, 0, mkc(0, 8'hFF, 3, 1) | 32'h001F_E006, "R11");
        wr(7, 0, 0);

        // R4: random mix against the reference model
        cur_req = "R4";
        for (int n = 0; n < 3000; n++) begin
            @(negedge clk);
            reg_we = ($urandom_range(0, 3) == 0);
            reg_sel_val = $urandom_range(0, 1);
            reg_idx = 4'($urandom_range(0, 15));
            if (reg_sel_val)
                reg_wdata = {20'h00012, 12'($urandom())};
            else
                reg_wdata = $urandom() & ~32'h1F00_0000 |
                            (32'($urandom_range(0, 2) == 0 ? $urandom_range(0, 14) : 0) << 24);
            acc_valid = $urandom_range(0, 1);
            acc_addr = {20'h00012, 12'($urandom())};
            acc_size = 2'($urandom_range(0, 3));
            acc_store = $urandom_range(0, 1);
        end
        @(negedge clk);
        reg_we = 0; acc_valid = 0;
        repeat (2) @(negedge clk);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule